// File: doc/BRIEF.md
# DDR Write-Burst Truncation Sequencer

This block sits on the controller side of a DDR SDRAM data interface and sequences a burst write that a later read may cut short. A write request is latched with its whole burst of data, the WRITE command goes out on the next cycle, and the data beats follow on the DQ bus one per cycle. If a read request arrives while the burst is still running, the block does not wait for the burst to finish. It computes the earliest legal slot for the READ command, masks every beat from the next cycle on with DM, stops DQS toggling on masked beats, and releases the DQ and DQS drivers so the memory can drive read data back.

The earliest slot honours both a hard two-cycle minimum after the WRITE command and a programmable write-to-read recovery gap. That gap is counted in whole idle cycles between the last committed beat and the READ. Until the slot arrives, the request is held inside the block and the command bus carries NOP. When the write is settled, a status pulse reports how many beats really reached the memory, so upstream logic can requeue the rest. One beat is modelled per clock, the burst length defaults to 8 and the read latency to 3.

Top module: `ddr_wr_intr_seq`

## Requirements
- R1: An accepted write request (wr_req with wr_ready high) makes cmd_code equal 1 (WRITE) with the latched bank and address on the next cycle, call it phase 0. Word k of wr_burst_data (bits k*DW upward) is driven on dq_out with dq_oe and dqs_oe high at phase k+1, for k from 0 to BL-1. Outside driven beats dq_out is zero.
- R2: A read accepted at write phase p, with p at most BL, puts cmd_code equal 2 (READ) with its bank and address at phase p+T+1. Here T is cfg_twtr, except that a value of 0 counts as 1. The READ is never issued earlier than phase 2.
- R3: A beat at a phase up to and including the accept phase p is driven with dm low. A beat after p that is still driven is driven with dm high.
- R4: From two cycles after the READ until the last read-data cycle, dq_oe and dqs_oe are low. This includes the cycle just before read data starts. Beats of the burst that fall in this window are not driven.
- R5: dqs_run is high exactly on driven beats that are not masked.
- R6: A read accepted at write phase p above BL is issued at phase max(BL+T+1, p+1).
- R7: A read accepted when no write has been issued for more than BL+2^TW cycles is issued on the next cycle.
- R8: While a read waits for its slot, cmd_code is 0 (NOP). rd_ready and wr_ready stay low from the cycle after acceptance through the last read-data cycle.
- R9: commit_vld pulses once per write. For a read accepted at a phase p below BL, it pulses in the READ cycle with commit_cnt equal to p. Otherwise it pulses at phase BL with commit_cnt equal to BL.
- R10: rd_capture is high for BL consecutive cycles, starting CL cycles after the READ.
- R11: wr_ready is high only from phase BL on, and only with no read waiting or in flight. When wr_req and rd_req are both high and a write can be taken, the write wins: rd_ready is low in that cycle.
- R12: A cfg_twtr of 0 gives the same timing as a cfg_twtr of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_twtr | input | TW | Write-to-read recovery gap in cycles (0 treated as 1) |
| wr_req | input | 1 | Write request |
| wr_bank | input | BA | Write bank |
| wr_addr | input | AW | Write column address |
| wr_burst_data | input | BL*DW | Whole write burst, word k at bits k*DW |
| wr_ready | output | 1 | A write can be taken this cycle |
| rd_req | input | 1 | Read request |
| rd_bank | input | BA | Read bank, any bank allowed |
| rd_addr | input | AW | Read column address |
| rd_ready | output | 1 | A read can be taken this cycle |
| cmd_code | output | 2 | 0 NOP, 1 WRITE, 2 READ |
| cmd_bank | output | BA | Bank of the current command, zero on NOP |
| cmd_addr | output | AW | Address of the current command, zero on NOP |
| dq_out | output | DW | Write data beat |
| dq_oe | output | 1 | DQ driver enable |
| dqs_oe | output | 1 | DQS driver enable |
| dqs_run | output | 1 | DQS toggle enable for the current beat |
| dm | output | 1 | Data mask for the current beat |
| rd_capture | output | 1 | Read data is on the bus this cycle |
| commit_vld | output | 1 | Commit count is valid this cycle |
| commit_cnt | output | $clog2(BL+1) | Beats written to memory for the settled write |

## Verification
The assertions take for granted that wr_req and rd_req are only counted when the matching ready output is high. They also assume cfg_twtr holds still from a read's acceptance until its READ is issued. The bench drives every request as a single-cycle pulse in a cycle where it has first seen the ready flag high. It changes cfg_twtr only while the block is idle, so the waiting-slot and masking properties only ever see stimulus they were written for.

// File: rtl/ddr_wir_pkg.sv
package ddr_wir_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2
  } cmd_e;

  // Recovery gap actually applied: at least one idle beat slot.
  function automatic int twtr_eff(input int cfg);
    return (cfg < 1) ? 1 : cfg;
  endfunction

  // Cycles from read acceptance (at write phase ph) to the READ command.
  function automatic int rd_wait(input int ph, input int t, input int bl);
    int lim;
    if (ph <= bl) return t + 1;
    lim = bl + t + 1;
    return (lim > ph) ? (lim - ph) : 1;
  endfunction

  // Beats already on the bus unmasked when a read is accepted at phase ph.
  function automatic int commit_of(input int ph, input int bl);
    return (ph < bl) ? ph : bl;
  endfunction

endpackage

// File: rtl/wir_wr_track.sv
module wir_wr_track #(
  parameter int DW     = 16,
  parameter int BA     = 2,
  parameter int AW     = 12,
  parameter int BL     = 8,
  parameter int PHW    = 5,
  parameter int PH_SAT = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_take,
  input  logic [BA-1:0]    wr_bank,
  input  logic [AW-1:0]    wr_addr,
  input  logic [BL*DW-1:0] wr_burst_data,
  output logic [PHW-1:0]   ph_q,
  output logic             beat_on,
  output logic [DW-1:0]    beat_word,
  output logic [BA-1:0]    wr_bank_q,
  output logic [AW-1:0]    wr_addr_q
);

  localparam logic [PHW-1:0] SAT_V = PHW'(PH_SAT);
  localparam logic [PHW-1:0] BL_V  = PHW'(BL);

  logic [BL*DW-1:0] data_q;
  logic [DW-1:0]    words [BL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= SAT_V;
      data_q    <= '0;
      wr_bank_q <= '0;
      wr_addr_q <= '0;
    end else if (wr_take) begin
      ph_q      <= '0;
      data_q    <= wr_burst_data;
      wr_bank_q <= wr_bank;
      wr_addr_q <= wr_addr;
    end else if (ph_q < SAT_V) begin
      ph_q <= ph_q + PHW'(1);
    end
  end

  for (genvar g = 0; g < BL; g++) begin : g_word
    assign words[g] = data_q[g*DW +: DW];
  end

  assign beat_on = (ph_q >= PHW'(1)) && (ph_q <= BL_V);

  always_comb begin
    beat_word = '0;
    for (int k = 0; k < BL; k++) begin
      if (ph_q == PHW'(k + 1)) beat_word = words[k];
    end
  end

endmodule

// File: rtl/wir_rd_sched.sv
module wir_rd_sched
  import ddr_wir_pkg::*;
#(
  parameter int BA   = 2,
  parameter int AW   = 12,
  parameter int BL   = 8,
  parameter int CL   = 3,
  parameter int PHW  = 5,
  parameter int TEW  = 4,
  parameter int RPHW = 4,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_take,
  input  logic [BA-1:0]   rd_bank,
  input  logic [AW-1:0]   rd_addr,
  input  logic [PHW-1:0]  ph_q,
  input  logic [TEW-1:0]  t_eff,
  output logic            rd_pend,
  output logic            rd_act,
  output logic [RPHW-1:0] rph,
  output logic            rd_issue,
  output logic            intr_q,
  output logic [CW-1:0]   cc_q,
  output logic [BA-1:0]   rd_bank_q,
  output logic [AW-1:0]   rd_addr_q
);

  localparam logic [RPHW-1:0] RPH_LAST = RPHW'(CL + BL - 1);
  localparam logic [PHW-1:0]  BL_V     = PHW'(BL);

  logic [PHW-1:0] wcnt;
  int             wait_n;

  always_comb wait_n = rd_wait(int'(ph_q), int'(t_eff), BL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      rd_act    <= 1'b0;
      rph       <= '0;
      wcnt      <= '0;
      intr_q    <= 1'b0;
      cc_q      <= '0;
      rd_bank_q <= '0;
      rd_addr_q <= '0;
    end else if (rd_take) begin
      rd_bank_q <= rd_bank;
      rd_addr_q <= rd_addr;
      intr_q    <= (ph_q < BL_V);
      cc_q      <= CW'(commit_of(int'(ph_q), BL));
      if (wait_n == 1) begin
        rd_act <= 1'b1;
        rph    <= '0;
      end else begin
        rd_pend <= 1'b1;
        wcnt    <= PHW'(wait_n - 2);
      end
    end else if (rd_pend) begin
      if (wcnt == '0) begin
        rd_pend <= 1'b0;
        rd_act  <= 1'b1;
        rph     <= '0;
      end else begin
        wcnt <= wcnt - PHW'(1);
      end
    end else if (rd_act) begin
      if (rph == RPH_LAST) rd_act <= 1'b0;
      else                 rph    <= rph + RPHW'(1);
    end
  end

  assign rd_issue = rd_act && (rph == '0);

endmodule

// File: rtl/wir_bus_ctl.sv
module wir_bus_ctl #(
  parameter int DW   = 16,
  parameter int BL   = 8,
  parameter int CL   = 3,
  parameter int PHW  = 5,
  parameter int RPHW = 4,
  parameter int CW   = 4
) (
  input  logic [PHW-1:0]  ph_q,
  input  logic            beat_on,
  input  logic [DW-1:0]   beat_word,
  input  logic            rd_pend,
  input  logic            rd_act,
  input  logic [RPHW-1:0] rph,
  input  logic            rd_issue,
  input  logic            intr_q,
  input  logic [CW-1:0]   cc_q,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  output logic            dqs_oe,
  output logic            dqs_run,
  output logic            dm,
  output logic            rd_capture,
  output logic            commit_vld,
  output logic [CW-1:0]   commit_cnt,
  output logic            released
);

  localparam logic [RPHW-1:0] RPH_CAP0 = RPHW'(CL);
  localparam logic [RPHW-1:0] RPH_CAP1 = RPHW'(CL + BL - 1);
  localparam logic [PHW-1:0]  BL_V     = PHW'(BL);

  logic drive;
  logic rd_busy;
  logic full_done;

  assign rd_busy   = rd_pend || rd_act;
  assign released  = rd_act && (rph >= RPHW'(2));
  assign drive     = beat_on && !released;
  assign dq_oe     = drive;
  assign dqs_oe    = drive;
  assign dm        = drive && rd_busy;
  assign dqs_run   = drive && !rd_busy;
  assign dq_out    = drive ? beat_word : '0;

  assign rd_capture = rd_act && (rph >= RPH_CAP0) && (rph <= RPH_CAP1);

  assign full_done  = (ph_q == BL_V) && !rd_busy;
  assign commit_vld = full_done || (rd_issue && intr_q);
  assign commit_cnt = full_done ? CW'(BL) : (commit_vld ? cc_q : '0);

endmodule

// File: rtl/ddr_wr_intr_seq.sv
module ddr_wr_intr_seq
  import ddr_wir_pkg::*;
#(
  parameter int DW = 16,
  parameter int BA = 2,
  parameter int AW = 12,
  parameter int BL = 8,
  parameter int CL = 3,
  parameter int TW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TW-1:0]            cfg_twtr,
  input  logic                     wr_req,
  input  logic [BA-1:0]            wr_bank,
  input  logic [AW-1:0]            wr_addr,
  input  logic [BL*DW-1:0]         wr_burst_data,
  output logic                     wr_ready,
  input  logic                     rd_req,
  input  logic [BA-1:0]            rd_bank,
  input  logic [AW-1:0]            rd_addr,
  output logic                     rd_ready,
  output logic [1:0]               cmd_code,
  output logic [BA-1:0]            cmd_bank,
  output logic [AW-1:0]            cmd_addr,
  output logic [DW-1:0]            dq_out,
  output logic                     dq_oe,
  output logic                     dqs_oe,
  output logic                     dqs_run,
  output logic                     dm,
  output logic                     rd_capture,
  output logic                     commit_vld,
  output logic [$clog2(BL+1)-1:0]  commit_cnt
);

  localparam int PH_SAT = BL + (1 << TW) + 1;
  localparam int PHW    = $clog2(PH_SAT + 1);
  localparam int TEW    = TW + 1;
  localparam int RPHW   = $clog2(CL + BL);
  localparam int CW     = $clog2(BL + 1);
  localparam logic [PHW-1:0] BL_V = PHW'(BL);

  // Named internal events, observed by the bound checker.
  logic [PHW-1:0]  ph_q;
  logic            beat_on;
  logic [DW-1:0]   beat_word;
  logic [BA-1:0]   wr_bank_q;
  logic [AW-1:0]   wr_addr_q;
  logic            rd_pend;
  logic            rd_act;
  logic [RPHW-1:0] rph;
  logic            rd_issue;
  logic            intr_q;
  logic [CW-1:0]   cc_q;
  logic [BA-1:0]   rd_bank_q;
  logic [AW-1:0]   rd_addr_q;
  logic            released;
  logic            wr_take;
  logic            rd_take;
  logic [TEW-1:0]  t_eff;
  cmd_e            cmd;

  assign t_eff    = TEW'(twtr_eff(int'(cfg_twtr)));
  assign wr_ready = (ph_q >= BL_V) && !rd_pend && !rd_act;
  assign wr_take  = wr_req && wr_ready;
  assign rd_ready = !rd_pend && !rd_act && !wr_take;
  assign rd_take  = rd_req && rd_ready;

  wir_wr_track #(
    .DW(DW), .BA(BA), .AW(AW), .BL(BL), .PHW(PHW), .PH_SAT(PH_SAT)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_take(wr_take),
    .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_burst_data(wr_burst_data),
    .ph_q(ph_q), .beat_on(beat_on), .beat_word(beat_word),
    .wr_bank_q(wr_bank_q), .wr_addr_q(wr_addr_q)
  );

  wir_rd_sched #(
    .BA(BA), .AW(AW), .BL(BL), .CL(CL), .PHW(PHW), .TEW(TEW),
    .RPHW(RPHW), .CW(CW)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_take(rd_take),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .ph_q(ph_q), .t_eff(t_eff),
    .rd_pend(rd_pend), .rd_act(rd_act), .rph(rph), .rd_issue(rd_issue),
    .intr_q(intr_q), .cc_q(cc_q), .rd_bank_q(rd_bank_q), .rd_addr_q(rd_addr_q)
  );

  wir_bus_ctl #(
    .DW(DW), .BL(BL), .CL(CL), .PHW(PHW), .RPHW(RPHW), .CW(CW)
  ) u_bus (
    .ph_q(ph_q), .beat_on(beat_on), .beat_word(beat_word),
    .rd_pend(rd_pend), .rd_act(rd_act), .rph(rph), .rd_issue(rd_issue),
    .intr_q(intr_q), .cc_q(cc_q),
    .dq_out(dq_out), .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs_run(dqs_run),
    .dm(dm), .rd_capture(rd_capture), .commit_vld(commit_vld),
    .commit_cnt(commit_cnt), .released(released)
  );

  always_comb begin
    cmd      = CMD_NOP;
    cmd_bank = '0;
    cmd_addr = '0;
    if (ph_q == '0) begin
      cmd      = CMD_WRITE;
      cmd_bank = wr_bank_q;
      cmd_addr = wr_addr_q;
    end else if (rd_issue) begin
      cmd      = CMD_READ;
      cmd_bank = rd_bank_q;
      cmd_addr = rd_addr_q;
    end
  end

  assign cmd_code = cmd;

endmodule

// File: rtl/wir_checker.sv
module wir_checker #(
  parameter int BL   = 8,
  parameter int PHW  = 5,
  parameter int RPHW = 4,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cmd_code,
  input logic [PHW-1:0]  ph_q,
  input logic            rd_pend,
  input logic            rd_act,
  input logic [RPHW-1:0] rph,
  input logic            rd_ready,
  input logic            wr_ready,
  input logic            dq_oe,
  input logic            dqs_oe,
  input logic            dqs_run,
  input logic            dm,
  input logic            rd_capture,
  input logic            commit_vld,
  input logic [CW-1:0]   commit_cnt
);

  assert_rd_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 2'd2) |-> (ph_q >= PHW'(2)));

  assert_read_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_pend) |-> (cmd_code == 2'd2));

  assert_mask_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_pend || rd_act) && dq_oe) |-> dm);

  assert_mask_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dm |-> dq_oe);

  assert_bus_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && rph >= RPHW'(2)) |-> (!dq_oe && !dqs_oe));

  assert_dqs_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_run |-> (dqs_oe && !dm));

  assert_wait_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> (cmd_code != 2'd2 && !rd_ready));

  assert_commit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> (commit_cnt <= CW'(BL)));

  assert_capture_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!dq_oe && rd_act));

  assert_wr_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!rd_pend && !rd_act));

endmodule

bind ddr_wr_intr_seq wir_checker #(
  .BL(BL), .PHW(PHW), .RPHW(RPHW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .ph_q(ph_q),
  .rd_pend(rd_pend), .rd_act(rd_act), .rph(rph), .rd_ready(rd_ready),
  .wr_ready(wr_ready), .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs_run(dqs_run),
  .dm(dm), .rd_capture(rd_capture), .commit_vld(commit_vld),
  .commit_cnt(commit_cnt)
);

// File: tb/ddr_wr_intr_seq_tb.sv
module ddr_wr_intr_seq_tb;

  localparam int DW = 16, BA = 2, AW = 12, BL = 8, CL = 3, TW = 3;
  localparam int CW = $clog2(BL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] cfg_twtr = '0;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [BA-1:0] wr_bank = '0, rd_bank = '0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [BL*DW-1:0] wr_burst_data = '0;
  logic wr_ready, rd_ready, dq_oe, dqs_oe, dqs_run, dm, rd_capture, commit_vld;
  logic [1:0] cmd_code;
  logic [BA-1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] dq_out;
  logic [CW-1:0] commit_cnt;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ddr_wr_intr_seq #(.DW(DW), .BA(BA), .AW(AW), .BL(BL), .CL(CL), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_twtr(cfg_twtr),
    .wr_req(wr_req), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_burst_data(wr_burst_data), .wr_ready(wr_ready),
    .rd_req(rd_req), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dqs_oe(dqs_oe), .dqs_run(dqs_run),
    .dm(dm), .rd_capture(rd_capture), .commit_vld(commit_vld),
    .commit_cnt(commit_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int seed, input int k);
    return DW'(16'h5a00 + seed * 37 + k * 11);
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One write burst, optionally cut by a read accepted at phase rd_ph.
  task automatic run_write(input int rd_ph, input int cfg, input int seed, input string rtag);
    bit rd;
    int teff, lastc, rslot, endp, lastp;
    rd    = (rd_ph >= 0);
    teff  = (cfg == 0) ? 1 : cfg;
    lastc = (rd_ph < BL) ? rd_ph : BL;
    rslot = (lastc + teff + 1 > rd_ph + 1) ? lastc + teff + 1 : rd_ph + 1;
    endp  = rd ? rslot + CL + BL - 1 : -1;
    lastp = rd ? endp + 2 : BL + 2;
    cfg_twtr = TW'(cfg);
    for (int k = 0; k < BL; k++) wr_burst_data[k*DW +: DW] = word_of(seed, k);
    wr_bank = BA'(seed);
    wr_addr = AW'(seed * 5 + 3);
    rd_bank = BA'(seed + 1);
    rd_addr = AW'(seed * 7 + 100);
    chk(wr_ready == 1'b1, "R11", "wr_ready before write", wr_ready, 1);
    wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    for (int p = 0; p <= lastp; p++) begin
      bit busy, beat, e_oe, e_dm, intr, e_cv;
      int e_cmd, e_cc;
      rd_req = 1'b0;
      busy  = rd && p > rd_ph && p <= endp;
      e_cmd = (p == 0) ? 1 : ((rd && p == rslot) ? 2 : 0);
      beat  = (p >= 1) && (p <= BL);
      e_oe  = beat && !(rd && p >= rslot + 2);
      e_dm  = e_oe && rd && p > rd_ph;
      intr  = rd && rd_ph < BL;
      e_cv  = intr ? (p == rslot) : (p == BL);
      e_cc  = intr ? rd_ph : BL;
      chk(int'(cmd_code) == e_cmd, (e_cmd == 1) ? "R1" : rtag, "cmd_code", cmd_code, e_cmd);
      if (e_cmd == 1) begin
        chk(cmd_bank == wr_bank && cmd_addr == wr_addr, "R1", "write addr", cmd_addr, wr_addr);
      end
      if (e_cmd == 2) begin
        chk(cmd_bank == rd_bank && cmd_addr == rd_addr, "R2", "read addr", cmd_addr, rd_addr);
      end
      chk(dq_oe == e_oe && dqs_oe == e_oe, "R4", "drive enable", dq_oe, e_oe);
      chk(dm == e_dm, "R3", "dm", dm, e_dm);
      chk(dqs_run == (e_oe && !e_dm), "R5", "dqs_run", dqs_run, e_oe && !e_dm);
      chk(dq_out == (e_oe ? word_of(seed, p - 1) : '0), "R1", "dq_out", dq_out,
          e_oe ? int'(word_of(seed, p - 1)) : 0);
      chk(rd_capture == (rd && p >= rslot + CL && p <= endp), "R10", "rd_capture",
          rd_capture, rd && p >= rslot + CL && p <= endp);
      chk(commit_vld == e_cv, "R9", "commit_vld", commit_vld, e_cv);
      if (e_cv) chk(int'(commit_cnt) == e_cc, "R9", "commit_cnt", commit_cnt, e_cc);
      chk(rd_ready == !busy, "R8", "rd_ready", rd_ready, !busy);
      chk(wr_ready == (p >= BL && !busy), "R11", "wr_ready", wr_ready, p >= BL && !busy);
      if (rd && p == rd_ph) rd_req = 1'b1;
      @(negedge clk);
    end
    rd_req = 1'b0;
  endtask

  // Read with no write in recent history.
  task automatic run_idle_read();
    idle_wait(25);
    cfg_twtr = TW'(4);
    rd_bank = 2'd3;
    rd_addr = 12'h2c4;
    chk(rd_ready == 1'b1, "R7", "rd_ready idle", rd_ready, 1);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    for (int q = 0; q <= CL + BL; q++) begin
      bit e_cap;
      e_cap = (q >= CL) && (q <= CL + BL - 1);
      chk(int'(cmd_code) == ((q == 0) ? 2 : 0), "R7", "idle read cmd", cmd_code, (q == 0) ? 2 : 0);
      if (q == 0) chk(cmd_bank == 2'd3 && cmd_addr == 12'h2c4, "R7", "idle read addr", cmd_addr, 12'h2c4);
      chk(rd_capture == e_cap, "R10", "idle capture", rd_capture, e_cap);
      chk(dq_oe == 1'b0 && dm == 1'b0, "R4", "idle bus quiet", dq_oe, 0);
      chk(commit_vld == 1'b0, "R9", "no commit on idle read", commit_vld, 0);
      chk(rd_ready == (q == CL + BL), "R8", "idle rd_ready", rd_ready, q == CL + BL);
      @(negedge clk);
    end
  endtask

  // Simultaneous requests: the write wins.
  task automatic run_priority();
    idle_wait(3);
    cfg_twtr = TW'(1);
    wr_bank = 2'd2; wr_addr = 12'h011;
    for (int k = 0; k < BL; k++) wr_burst_data[k*DW +: DW] = word_of(9, k);
    wr_req = 1'b1;
    rd_req = 1'b1;
    #1;
    chk(rd_ready == 1'b0, "R11", "rd_ready under collision", rd_ready, 0);
    @(negedge clk);
    wr_req = 1'b0;
    rd_req = 1'b0;
    chk(int'(cmd_code) == 1, "R11", "write wins", cmd_code, 1);
    idle_wait(BL + 3);
    chk(int'(cmd_code) == 0 && rd_ready == 1'b1, "R11", "read was not taken", cmd_code, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual=expired expected=done");
    total++;
    bad++;
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_code == 2'd0 && dq_oe == 1'b0 && dqs_oe == 1'b0, "R1", "reset bus idle", cmd_code, 0);
    chk(dm == 1'b0 && rd_capture == 1'b0 && commit_vld == 1'b0, "R9", "reset status", commit_vld, 0);
    chk(wr_ready == 1'b1 && rd_ready == 1'b1, "R11", "reset ready", wr_ready, 1);
    run_write(-1, 2, 1, "R1");   // full burst, no read
    run_write(3, 1, 2, "R2");    // mid-burst cut
    run_write(0, 1, 3, "R2");    // earliest request, 2-cycle floor
    run_write(2, 3, 4, "R2");    // long recovery gap
    run_write(5, 0, 5, "R12");   // gap of 0 acts as 1
    run_write(5, 1, 6, "R12");   // same timing with 1
    run_write(8, 1, 7, "R6");    // read on last beat
    run_write(9, 2, 8, "R6");    // read after burst, gap still counting
    run_write(14, 1, 10, "R6");  // read after gap elapsed
    run_write(6, 7, 11, "R2");   // gap longer than remaining burst
    run_idle_read();
    run_priority();
    idle_wait(2);
    finish_run();
  end

endmodule